// File: doc/BRIEF.md
# Decode-Stage Hazard Controller

This block holds the hazard control for an in-order, five-stage pipeline that settles conditional branches in the decode stage. It watches the instruction in the execute stage and the one in decode. If the execute-stage instruction is a load whose destination register is a source of the decode-stage instruction, the block holds the fetch address and the fetch/decode register for one cycle. In that same cycle it zeroes the control bits headed into the decode/execute register, so that register receives a bubble. After that single cycle, operand forwarding in the datapath supplies the loaded value.

The block also decides branch outcomes in decode. It forms a bitwise difference of the two register operands and reduces it with an OR, so the operands are equal exactly when that reduction is zero. The pipeline always fetches down the fall-through path. When a decode-stage branch finds its operands equal, the block selects the branch target for the next fetch. It also squashes the single wrong-path instruction by writing an all-zero word, which is a no-op, into the fetch/decode register. This costs one cycle per taken branch. A load-use stall has priority over a branch in the same cycle, so the branch is judged again once the stall has cleared. The block is purely combinational and has no clock.

Top module: `hzd_pipe_ctrl`

## Requirements
- R1: `hold_stall` is 1 when `ex_is_load` is 1, `ex_dst_reg` is not 0, and `ex_dst_reg` equals `id_src_a`.
- R2: `hold_stall` is 1 when `ex_is_load` is 1, `ex_dst_reg` is not 0, and `ex_dst_reg` equals `id_src_b`.
- R3: A load whose destination is register 0 never raises `hold_stall`, whatever the source registers are.
- R4: `hold_stall` is 0 when `ex_is_load` is 0, or when `ex_dst_reg` matches neither source register.
- R5: While `hold_stall` is 1, `pc_wr_en` is 0, `fd_wr_en` is 0, `dx_ctl_zero` is 1 and `dx_ctl_out` is all zeros.
- R6: While `hold_stall` is 0, `pc_wr_en` and `fd_wr_en` are 1, `dx_ctl_zero` is 0, and `dx_ctl_out` equals `dx_ctl_in`.
- R7: `opnd_equal` is 1 exactly when `id_opnd_a` equals `id_opnd_b` in every bit.
- R8: When `id_is_branch` is 1, the operands are equal and there is no stall, `fd_flush` is 1 and `pc_src_sel` is 1 (1 selects the branch target, 0 selects the sequential address).
- R9: While `fd_flush` is 1, `fd_word_out` is all zeros. Otherwise it equals `fetch_word`.
- R10: When a stall and a taken-branch condition occur together, `fd_flush` is 0 and `pc_src_sel` is 0, because the stall wins.
- R11: When `id_is_branch` is 0 or the operands differ, `fd_flush` is 0 and `pc_src_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_is_load | input | 1 | Execute-stage instruction reads data memory |
| ex_dst_reg | input | REG_W | Destination register of the execute-stage instruction |
| id_src_a | input | REG_W | First source register of the decode-stage instruction |
| id_src_b | input | REG_W | Second source register of the decode-stage instruction |
| id_is_branch | input | 1 | Decode-stage instruction is a branch-on-equal |
| id_opnd_a | input | DATA_W | First register operand value in decode |
| id_opnd_b | input | DATA_W | Second register operand value in decode |
| dx_ctl_in | input | CTL_W | Decoded control bits for the decode/execute register |
| fetch_word | input | INSTR_W | Instruction word just fetched |
| hold_stall | output | 1 | Load-use stall active |
| pc_wr_en | output | 1 | Fetch address register may update |
| fd_wr_en | output | 1 | Fetch/decode register may update |
| dx_ctl_zero | output | 1 | Forces decode/execute control bits to zero |
| dx_ctl_out | output | CTL_W | Control bits to load into decode/execute |
| opnd_equal | output | 1 | Decode operands are equal |
| fd_flush | output | 1 | Squash the wrong-path instruction |
| pc_src_sel | output | 1 | Next fetch address: 0 sequential, 1 branch target |
| fd_word_out | output | INSTR_W | Word to load into fetch/decode |

## Verification
Directed vectors place the load destination on the first source, on the second source, on both sources, and on neither. They also set it to register 0 while it matches a source. Together these separate the two comparison paths and show that the zero-register guard works. Branch vectors use equal operands, operands that differ in only the lowest bit or only the highest bit, and equal operands during a stall. These show that every bit reaches the equality reduction and that the stall takes priority. Random vectors draw registers from a narrow range so that matches are common, and make the operands equal about half the time, which mixes all of these cases.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
   typedef enum logic {
      PCSEL_SEQ    = 1'b0,
      PCSEL_TARGET = 1'b1
   } pc_sel_e;

   localparam int EQ_FLAT  = 0;
   localparam int EQ_CHUNK = 1;
endpackage

// File: rtl/hzd_loaduse_detect.sv
module hzd_loaduse_detect #(
   parameter int REG_W = 5,
   parameter bit GUARD_ZERO_DST = 1'b1
) (
   input  logic             ex_is_load,
   input  logic [REG_W-1:0] ex_dst_reg,
   input  logic [REG_W-1:0] id_src_a,
   input  logic [REG_W-1:0] id_src_b,
   output logic             stall
);
   logic hit_a;
   logic hit_b;
   logic dst_live;

   generate
      if (REG_W < 1) begin : g_bad_w
         $error("REG_W must be at least 1");
      end
      if (GUARD_ZERO_DST) begin : g_guard
         assign dst_live = |ex_dst_reg;
      end else begin : g_noguard
         assign dst_live = 1'b1;
      end
   endgenerate

   assign hit_a = (ex_dst_reg == id_src_a);
   assign hit_b = (ex_dst_reg == id_src_b);
   assign stall = ex_is_load & dst_live & (hit_a | hit_b);

   always_comb begin
      if (GUARD_ZERO_DST && ex_dst_reg == '0)
         assert_zero_dst_R3 : assert (!stall);
      if (!ex_is_load)
         assert_no_load_R4 : assert (!stall);
   end
endmodule

// File: rtl/hzd_eq_compare.sv
module hzd_eq_compare #(
   parameter int DATA_W  = 32,
   parameter int EQ_MODE = hzd_pkg::EQ_CHUNK,
   parameter int CHUNK_W = 8
) (
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   output logic              equal
);
   localparam int N_GRP = (DATA_W + CHUNK_W - 1) / CHUNK_W;
   localparam int PAD_W = N_GRP * CHUNK_W;

   logic [DATA_W-1:0] diff;
   assign diff = opnd_a ^ opnd_b;

   generate
      if (DATA_W < 1 || CHUNK_W < 1) begin : g_bad_w
         $error("DATA_W and CHUNK_W must be at least 1");
      end
      if (EQ_MODE == hzd_pkg::EQ_FLAT) begin : g_flat
         assign equal = ~(|diff);
      end else begin : g_chunk
         logic [PAD_W-1:0] diff_pad;
         logic [N_GRP-1:0] grp_any;
         assign diff_pad = PAD_W'(diff);
         for (genvar g = 0; g < N_GRP; g++) begin : g_grp
            assign grp_any[g] = |diff_pad[g*CHUNK_W +: CHUNK_W];
         end
         assign equal = ~(|grp_any);
      end
   endgenerate

   always_comb begin
      assert_eq_match_R7 : assert (equal == (opnd_a == opnd_b));
   end
endmodule

// File: rtl/hzd_branch_resolve.sv
module hzd_branch_resolve
   import hzd_pkg::*;
(
   input  logic    id_is_branch,
   input  logic    opnd_equal,
   input  logic    stall,
   output logic    flush,
   output pc_sel_e pc_sel
);
   logic taken;

   assign taken  = id_is_branch & opnd_equal & ~stall;
   assign flush  = taken;
   assign pc_sel = taken ? PCSEL_TARGET : PCSEL_SEQ;

   always_comb begin
      if (!id_is_branch || !opnd_equal)
         assert_no_redirect_R11 : assert (!flush && pc_sel == PCSEL_SEQ);
   end
endmodule

// File: rtl/hzd_pipe_ctrl.sv
module hzd_pipe_ctrl
   import hzd_pkg::*;
#(
   parameter int REG_W          = 5,
   parameter int DATA_W         = 32,
   parameter int INSTR_W        = 32,
   parameter int CTL_W          = 4,
   parameter int EQ_MODE        = EQ_CHUNK,
   parameter int CHUNK_W        = 8,
   parameter bit GUARD_ZERO_DST = 1'b1
) (
   input  logic               ex_is_load,
   input  logic [REG_W-1:0]   ex_dst_reg,
   input  logic [REG_W-1:0]   id_src_a,
   input  logic [REG_W-1:0]   id_src_b,
   input  logic               id_is_branch,
   input  logic [DATA_W-1:0]  id_opnd_a,
   input  logic [DATA_W-1:0]  id_opnd_b,
   input  logic [CTL_W-1:0]   dx_ctl_in,
   input  logic [INSTR_W-1:0] fetch_word,
   output logic               hold_stall,
   output logic               pc_wr_en,
   output logic               fd_wr_en,
   output logic               dx_ctl_zero,
   output logic [CTL_W-1:0]   dx_ctl_out,
   output logic               opnd_equal,
   output logic               fd_flush,
   output logic               pc_src_sel,
   output logic [INSTR_W-1:0] fd_word_out
);
   localparam logic [INSTR_W-1:0] NOP_WORD = '0;

   logic    stall_w;
   logic    eq_w;
   logic    flush_w;
   pc_sel_e sel_w;

   generate
      if (CTL_W < 1 || INSTR_W < 1) begin : g_bad_w
         $error("CTL_W and INSTR_W must be at least 1");
      end
   endgenerate

   hzd_loaduse_detect #(
      .REG_W          (REG_W),
      .GUARD_ZERO_DST (GUARD_ZERO_DST)
   ) u_detect (
      .ex_is_load (ex_is_load),
      .ex_dst_reg (ex_dst_reg),
      .id_src_a   (id_src_a),
      .id_src_b   (id_src_b),
      .stall      (stall_w)
   );

   hzd_eq_compare #(
      .DATA_W  (DATA_W),
      .EQ_MODE (EQ_MODE),
      .CHUNK_W (CHUNK_W)
   ) u_cmp (
      .opnd_a (id_opnd_a),
      .opnd_b (id_opnd_b),
      .equal  (eq_w)
   );

   hzd_branch_resolve u_branch (
      .id_is_branch (id_is_branch),
      .opnd_equal   (eq_w),
      .stall        (stall_w),
      .flush        (flush_w),
      .pc_sel       (sel_w)
   );

   assign hold_stall  = stall_w;
   assign pc_wr_en    = ~stall_w;
   assign fd_wr_en    = ~stall_w;
   assign dx_ctl_zero = stall_w;
   assign dx_ctl_out  = stall_w ? '0 : dx_ctl_in;
   assign opnd_equal  = eq_w;
   assign fd_flush    = flush_w;
   assign pc_src_sel  = (sel_w == PCSEL_TARGET);
   assign fd_word_out = flush_w ? NOP_WORD : fetch_word;

   always_comb begin
      if (stall_w)
         assert_stall_wins_R10 : assert (!flush_w && sel_w == PCSEL_SEQ);
      if (flush_w)
         assert_flush_nop_R9 : assert (fd_word_out == '0 && fd_wr_en);
      if (stall_w)
         assert_bubble_R5 : assert (dx_ctl_out == '0 && !pc_wr_en);
   end
endmodule

// File: tb/hzd_pipe_ctrl_bench.sv
module hzd_pipe_ctrl_bench;
   localparam int REG_W   = 5;
   localparam int DATA_W  = 32;
   localparam int INSTR_W = 32;
   localparam int CTL_W   = 4;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic               ex_is_load;
   logic [REG_W-1:0]   ex_dst_reg, id_src_a, id_src_b;
   logic               id_is_branch;
   logic [DATA_W-1:0]  id_opnd_a, id_opnd_b;
   logic [CTL_W-1:0]   dx_ctl_in;
   logic [INSTR_W-1:0] fetch_word;
   logic               hold_stall, pc_wr_en, fd_wr_en, dx_ctl_zero;
   logic [CTL_W-1:0]   dx_ctl_out;
   logic               opnd_equal, fd_flush, pc_src_sel;
   logic [INSTR_W-1:0] fd_word_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   hzd_pipe_ctrl u_hzd_pipe_ctrl (.*);

   function automatic bit exp_stall(input bit ld, input logic [REG_W-1:0] d,
                                    input logic [REG_W-1:0] a, input logic [REG_W-1:0] b);
      return ld && (d != 0) && (d == a || d == b);
   endfunction

   function automatic string stall_tag(input bit ld, input logic [REG_W-1:0] d,
                                       input logic [REG_W-1:0] a, input logic [REG_W-1:0] b);
      if (ld && d == 0) return "R3";
      if (!ld || (d != a && d != b)) return "R4";
      if (d == a) return "R1";
      return "R2";
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic apply(input bit ld, input logic [REG_W-1:0] d, input logic [REG_W-1:0] a,
                        input logic [REG_W-1:0] b, input bit br, input logic [DATA_W-1:0] oa,
                        input logic [DATA_W-1:0] ob, input logic [CTL_W-1:0] ctl,
                        input logic [INSTR_W-1:0] fw);
      bit st, eq, tk;
      @(negedge clk);
      ex_is_load = ld; ex_dst_reg = d; id_src_a = a; id_src_b = b;
      id_is_branch = br; id_opnd_a = oa; id_opnd_b = ob; dx_ctl_in = ctl; fetch_word = fw;
      #1;
      st = exp_stall(ld, d, a, b);
      eq = (oa == ob);
      tk = br && eq && !st;
      chk(stall_tag(ld, d, a, b), 64'(hold_stall), 64'(st));
      if (st) begin
         chk("R5", 64'({pc_wr_en, fd_wr_en, dx_ctl_zero}), 64'(3'b001));
         chk("R5", 64'(dx_ctl_out), 64'(0));
      end else begin
         chk("R6", 64'({pc_wr_en, fd_wr_en, dx_ctl_zero}), 64'(3'b110));
         chk("R6", 64'(dx_ctl_out), 64'(ctl));
      end
      chk("R7", 64'(opnd_equal), 64'(eq));
      if (tk)
         chk("R8", 64'({fd_flush, pc_src_sel}), 64'(2'b11));
      else if (br && eq)
         chk("R10", 64'({fd_flush, pc_src_sel}), 64'(2'b00));
      else
         chk("R11", 64'({fd_flush, pc_src_sel}), 64'(2'b00));
      chk("R9", 64'(fd_word_out), 64'(tk ? '0 : fw));
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // reset-like idle vector: no load, no branch
      apply(0, 0, 0, 0, 0, 0, 1, 4'hF, 32'h1234_5678);
      // R1: destination matches first source
      apply(1, 5'd7, 5'd7, 5'd3, 0, 1, 2, 4'hA, 32'hDEAD_0001);
      // R2: destination matches second source
      apply(1, 5'd9, 5'd2, 5'd9, 0, 1, 2, 4'h5, 32'hDEAD_0002);
      // both sources match
      apply(1, 5'd31, 5'd31, 5'd31, 0, 0, 0, 4'hF, 32'h0000_00FF);
      // R3: load to register 0 with matching sources
      apply(1, 5'd0, 5'd0, 5'd0, 0, 0, 0, 4'hF, 32'h1111_1111);
      // R4: match but no load; load but no match
      apply(0, 5'd6, 5'd6, 5'd6, 0, 0, 0, 4'h3, 32'h2222_2222);
      apply(1, 5'd6, 5'd5, 5'd4, 0, 0, 0, 4'h3, 32'h2222_2223);
      // R8 / R9: taken branch squashes fetched word
      apply(0, 5'd1, 5'd2, 5'd3, 1, 32'hCAFE_F00D, 32'hCAFE_F00D, 4'h1, 32'h3333_3333);
      // R11: operands differ only in bit 0 and only in bit 31
      apply(0, 5'd1, 5'd2, 5'd3, 1, 32'h0000_0000, 32'h0000_0001, 4'h1, 32'h4444_4444);
      apply(0, 5'd1, 5'd2, 5'd3, 1, 32'h0000_0000, 32'h8000_0000, 4'h1, 32'h4444_4445);
      // R10: stall and taken branch together, then branch retried
      apply(1, 5'd8, 5'd8, 5'd1, 1, 32'h55, 32'h55, 4'hE, 32'h5555_5555);
      apply(0, 5'd8, 5'd8, 5'd1, 1, 32'h55, 32'h55, 4'hE, 32'h5555_5555);
      // random mix with a fixed seed
      void'($urandom(32'h1F2E_3D4C));
      for (int i = 0; i < 400; i++) begin
         logic [DATA_W-1:0] oa;
         logic [DATA_W-1:0] ob;
         oa = $urandom;
         ob = ($urandom_range(0, 1) == 0) ? oa : (oa ^ (32'h1 << $urandom_range(0, 31)));
         apply(1'($urandom_range(0, 1)), 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
               5'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), oa, ob,
               4'($urandom), 32'($urandom));
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule